// File: doc/BRIEF.md
# Receive Sample Point Control Register

This block is a single 32-bit control word on a simple register bus. Software writes whole words and reads the current contents back at any time. Most fields are plain storage. Three of them drive pins directly: a soft reset, a fast-path select and an internal loopback select.

One 3-bit field is special. It holds a forced receive sample point, and a write changes it only when a separate qualifier bit in the same write is 1. The qualifier itself is never stored. A mode bit chooses what the block presents as the effective sample point. With the mode bit clear, the effective value is the forced field. With it set, the effective value is taken from an automatic timing manager, which arrives on an input port.

The automatic selection algorithm is outside this block, and so is the serial datapath.

Top module: `rx_sample_ctl_reg`

## Requirements
- R1: While `rst` is high at a clock edge, the register goes to 32'h0300_0000. That is a forced sample value of 3 in bits 26:24, with every other field 0. `eff_sample` then reads 3.
- R2: A write with bit 23 of `reg_wdata` equal to 1 loads `reg_wdata[26:24]` into the forced sample field at the next clock edge.
- R3: A write with bit 23 equal to 0 leaves the forced sample field unchanged. The other writable fields in the same write still update.
- R4: Bit 23 is a write strobe only and always reads back as 0.
- R5: Reserved bits 29:27, 20:19 and 7:3 always read as 0, whatever has been written to them.
- R6: When the auto-select bit (bit 22) reads 0, `eff_sample` equals the forced field, bits 26:24.
- R7: When bit 22 reads 1, `eff_sample` equals `auto_sample` and ignores the forced field. The forced field can still be written under the qualifier while bit 22 is 1.
- R8: `soft_reset` follows bit 0, `loopback` follows bit 1 and `fast_path` follows bit 21, all taken straight from the stored register.
- R9: The writable bits outside the sample field take the written value on each write and read back unchanged. These are bits 31, 30, 22, 21, 18:16, 15:8, 2, 1 and 0, which together form the mask 32'hC067_FF07.
- R10: While `reg_wr` is low, the register keeps its value whatever `reg_wdata` carries.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr | input | 1 | Word write strobe |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Current register contents, reserved bits and bit 23 as 0 |
| auto_sample | input | 3 | Sample point chosen by the automatic timing manager |
| eff_sample | output | 3 | Effective receive sample point |
| soft_reset | output | 1 | Soft reset select, bit 0 |
| loopback | output | 1 | Internal loopback select, bit 1 |
| fast_path | output | 1 | Fast-path select, bit 21 |

## Verification
The hardest case to reach is a write that changes the forced field while auto-select is on. The port shows nothing at the time of that write. The result only appears once auto-select is cleared again.

The bench writes a qualified sample value with bit 22 set and checks that `eff_sample` still tracks `auto_sample`. It then clears bit 22 with an unqualified write. That write must not disturb the forced field, so the value written earlier should now appear on `eff_sample`.

A write of all ones is also applied. It sets the qualifier and every reserved bit at once, and the bench checks that the read-back is exactly the writable mask.

// File: rtl/rx_sample_ctl_pkg.sv
package rx_sample_ctl_pkg;

    localparam int WORD_W   = 32;
    localparam int SMP_W    = 3;
    localparam int QUAL_BIT = 23;

    // Field layout of the control word, most significant bit first.
    typedef struct packed {
        logic             pwr_save;      // 31
        logic             clk_pull_off;  // 30
        logic [2:0]       rsv_hi;        // 29:27
        logic [SMP_W-1:0] sample;        // 26:24
        logic             qual;          // 23, strobe only
        logic             auto_en;       // 22
        logic             fast_path;     // 21
        logic [1:0]       rsv_mid;       // 20:19
        logic [2:0]       clk_div;       // 18:16
        logic             clk_out;       // 15
        logic             irq_fwd;       // 14
        logic             irq_en;        // 13
        logic [4:0]       irq_idx;       // 12:8
        logic [4:0]       rsv_lo;        // 7:3
        logic             opt_off;       // 2
        logic             loopback;      // 1
        logic             soft_reset;    // 0
    } ctrl_t;

    localparam logic [WORD_W-1:0] RESET_WORD = 32'h0300_0000;
    localparam logic [WORD_W-1:0] PLAIN_MASK = 32'hC067_FF07;
    localparam logic [WORD_W-1:0] SMP_MASK   = 32'h0700_0000;

    // Clear every bit that is not storage.
    function automatic ctrl_t scrub(ctrl_t c);
        ctrl_t r;
        r         = c;
        r.rsv_hi  = '0;
        r.rsv_mid = '0;
        r.rsv_lo  = '0;
        r.qual    = 1'b0;
        return r;
    endfunction

    // Next stored value after a word write.
    function automatic ctrl_t merge(ctrl_t old, logic [WORD_W-1:0] w);
        logic [WORD_W-1:0] sel;
        logic [WORD_W-1:0] o;
        sel = PLAIN_MASK | (w[QUAL_BIT] ? SMP_MASK : '0);
        o   = old;
        return scrub(ctrl_t'((o & ~sel) | (w & sel)));
    endfunction

endpackage

// File: rtl/rsc_field_store.sv
module rsc_field_store
    import rx_sample_ctl_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [WORD_W-1:0] wr_word,
    output ctrl_t             state
);

    always_ff @(posedge clk) begin
        if (rst) begin
            state <= ctrl_t'(RESET_WORD);
        end else if (wr_en) begin
            state <= merge(state, wr_word);
        end
    end

endmodule

// File: rtl/rsc_read_view.sv
module rsc_read_view
    import rx_sample_ctl_pkg::*;
(
    input  ctrl_t             state,
    output logic [WORD_W-1:0] rd_word
);

    always_comb begin
        rd_word = scrub(state);
    end

endmodule

// File: rtl/rsc_sample_sel.sv
module rsc_sample_sel #(
    parameter int W = 3
) (
    input  logic         auto_en,
    input  logic [W-1:0] forced_val,
    input  logic [W-1:0] auto_val,
    output logic [W-1:0] chosen
);

    always_comb begin
        chosen = auto_en ? auto_val : forced_val;
    end

endmodule

// File: rtl/rx_sample_ctl_reg.sv
module rx_sample_ctl_reg
    import rx_sample_ctl_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              reg_wr,
    input  logic [WORD_W-1:0] reg_wdata,
    output logic [WORD_W-1:0] reg_rdata,
    input  logic [SMP_W-1:0]  auto_sample,
    output logic [SMP_W-1:0]  eff_sample,
    output logic              soft_reset,
    output logic              loopback,
    output logic              fast_path
);

    ctrl_t state;

    rsc_field_store u_store (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (reg_wr),
        .wr_word (reg_wdata),
        .state   (state)
    );

    rsc_read_view u_view (
        .state   (state),
        .rd_word (reg_rdata)
    );

    rsc_sample_sel #(.W(SMP_W)) u_sel (
        .auto_en    (state.auto_en),
        .forced_val (state.sample),
        .auto_val   (auto_sample),
        .chosen     (eff_sample)
    );

    assign soft_reset = state.soft_reset;
    assign loopback   = state.loopback;
    assign fast_path  = state.fast_path;

endmodule

// File: rtl/rsc_checker.sv
module rsc_checker
    import rx_sample_ctl_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic              reg_wr,
    input logic [WORD_W-1:0] reg_wdata,
    input logic [WORD_W-1:0] reg_rdata,
    input logic [SMP_W-1:0]  auto_sample,
    input logic [SMP_W-1:0]  eff_sample,
    input logic              soft_reset,
    input logic              loopback,
    input logic              fast_path
);

    assert_reset_value_R1: assert property (@(posedge clk)
        rst |=> (reg_rdata == RESET_WORD));

    assert_qual_load_R2: assert property (@(posedge clk) disable iff (rst)
        (reg_wr && reg_wdata[QUAL_BIT]) |=> (reg_rdata[26:24] == $past(reg_wdata[26:24])));

    assert_unqual_hold_R3: assert property (@(posedge clk) disable iff (rst)
        (reg_wr && !reg_wdata[QUAL_BIT]) |=> $stable(reg_rdata[26:24]));

    assert_strobe_zero_R4: assert property (@(posedge clk) disable iff (rst)
        reg_wr |=> (reg_rdata[QUAL_BIT] == 1'b0));

    assert_reserved_zero_R5: assert property (@(posedge clk) disable iff (rst)
        reg_wr |=> ((reg_rdata[29:27] == 3'b0) && (reg_rdata[20:19] == 2'b0) && (reg_rdata[7:3] == 5'b0)));

    assert_forced_sel_R6: assert property (@(posedge clk) disable iff (rst)
        !reg_rdata[22] |-> (eff_sample == reg_rdata[26:24]));

    assert_auto_sel_R7: assert property (@(posedge clk) disable iff (rst)
        reg_rdata[22] |-> (eff_sample == auto_sample));

    assert_pin_follow_R8: assert property (@(posedge clk) disable iff (rst)
        (soft_reset == reg_rdata[0]) && (loopback == reg_rdata[1]) && (fast_path == reg_rdata[21]));

    assert_plain_fields_R9: assert property (@(posedge clk) disable iff (rst)
        reg_wr |=> ((reg_rdata & PLAIN_MASK) == ($past(reg_wdata) & PLAIN_MASK)));

    assert_idle_hold_R10: assert property (@(posedge clk) disable iff (rst)
        !reg_wr |=> $stable(reg_rdata));

endmodule

bind rx_sample_ctl_reg rsc_checker u_chk (
    .clk         (clk),
    .rst         (rst),
    .reg_wr      (reg_wr),
    .reg_wdata   (reg_wdata),
    .reg_rdata   (reg_rdata),
    .auto_sample (auto_sample),
    .eff_sample  (eff_sample),
    .soft_reset  (soft_reset),
    .loopback    (loopback),
    .fast_path   (fast_path)
);

// File: tb/rx_sample_ctl_reg_bench.sv
module rx_sample_ctl_reg_bench;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        reg_wr = 1'b0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic [2:0]  auto_sample = '0;
    logic [2:0]  eff_sample;
    logic        soft_reset, loopback, fast_path;

    int checks = 0;
    int errs   = 0;

    always #5 clk = ~clk;

    rx_sample_ctl_reg u_rx_sample_ctl_reg (
        .clk         (clk),
        .rst         (rst),
        .reg_wr      (reg_wr),
        .reg_wdata   (reg_wdata),
        .reg_rdata   (reg_rdata),
        .auto_sample (auto_sample),
        .eff_sample  (eff_sample),
        .soft_reset  (soft_reset),
        .loopback    (loopback),
        .fast_path   (fast_path)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errs++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // One write cycle; the result is visible at the negedge after the write edge.
    task automatic write_word(input logic [31:0] d);
        @(negedge clk);
        reg_wr    = 1'b1;
        reg_wdata = d;
        @(negedge clk);
        reg_wr    = 1'b0;
        reg_wdata = '0;
    endtask

    task automatic apply_reset();
        @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        @(negedge clk);
        rst = 1'b0;
    endtask

    task automatic t_reset();
        check("R1 reset word", reg_rdata, 32'h0300_0000);
        check("R1 reset eff_sample", {29'b0, eff_sample}, 32'd3);
        check("R8 reset pins", {29'b0, fast_path, loopback, soft_reset}, 32'd0);
    endtask

    task automatic t_qualified();
        write_word(32'h0580_0000);
        check("R2 qualified load", reg_rdata, 32'h0500_0000);
        check("R4 strobe reads 0", {31'b0, reg_rdata[23]}, 32'd0);
        check("R6 forced used", {29'b0, eff_sample}, 32'd5);
    endtask

    task automatic t_unqualified();
        write_word(32'h0700_0000);
        check("R3 unqualified hold", reg_rdata, 32'h0500_0000);
        write_word(32'h0200_0001);
        check("R3 others update, sample held", reg_rdata, 32'h0500_0001);
        check("R8 soft_reset", {31'b0, soft_reset}, 32'd1);
        check("R6 forced after unqual", {29'b0, eff_sample}, 32'd5);
    endtask

    task automatic t_all_ones();
        auto_sample = 3'd2;
        write_word(32'hFFFF_FFFF);
        check("R5/R9 all ones masked", reg_rdata, 32'hC767_FF07);
        check("R8 pins all set", {29'b0, fast_path, loopback, soft_reset}, 32'd7);
        check("R7 auto value used", {29'b0, eff_sample}, 32'd2);
    endtask

    task automatic t_auto_sweep();
        for (int i = 0; i < 8; i++) begin
            @(negedge clk);
            auto_sample = 3'(i);
            #1;
            check("R7 auto sweep", {29'b0, eff_sample}, 32'(i));
        end
        // Qualified write of 1 while auto is on: stored, yet not shown.
        auto_sample = 3'd6;
        write_word(32'h01C0_0000);
        check("R7 forced written under auto", reg_rdata, 32'h0140_0000);
        check("R7 forced ignored", {29'b0, eff_sample}, 32'd6);
        // Leave auto via unqualified write: earlier forced value appears.
        write_word(32'h0000_0000);
        check("R3 clear auto keeps sample", reg_rdata, 32'h0100_0000);
        check("R6 forced after auto off", {29'b0, eff_sample}, 32'd1);
    endtask

    task automatic t_idle();
        @(negedge clk);
        reg_wdata = 32'hFFFF_FFFF;
        repeat (3) @(negedge clk);
        check("R10 idle hold", reg_rdata, 32'h0100_0000);
        reg_wdata = '0;
    endtask

    task automatic t_fields();
        write_word(32'h8000_A502);
        check("R9 field pattern A", reg_rdata, 32'h8100_A502);
        check("R8 loopback only", {29'b0, fast_path, loopback, soft_reset}, 32'd2);
        write_word(32'h4025_4600);
        check("R9 field pattern B", reg_rdata, 32'h4125_4600);
        check("R8 fast_path only", {29'b0, fast_path, loopback, soft_reset}, 32'd4);
    endtask

    task automatic t_reset_again();
        write_word(32'hC7E7_FF07);
        apply_reset();
        check("R1 reset after use", reg_rdata, 32'h0300_0000);
        check("R1 eff after reset", {29'b0, eff_sample}, 32'd3);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        t_reset();
        t_qualified();
        t_unqualified();
        t_all_ones();
        t_auto_sweep();
        t_idle();
        t_fields();
        t_reset_again();
        $display("Result: errors=%0d of %0d checks", errs, checks);
        $finish;
    end

    initial begin
        repeat (5000) @(posedge clk);
        checks++;
        errs++;
        $display("FAIL watchdog expired");
        $display("Result: errors=%0d of %0d checks", errs, checks);
        $finish;
    end

endmodule